// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output cell of a small sum-of-products programmable logic device. It receives the product terms that an external AND array has already formed for it. It also receives two device-wide mode bits and two bits of its own: one picks the cell's role and one picks the output polarity. From these it builds a pad that is registered, combinatorial, tri-stated by a product term, or used only as an input. It also produces the signal that goes back into the array. The pad is modelled as separate input, output and driver-enable signals.

The cell's position in the row of cells is a parameter. The two outermost cells steer their feedback selector from the other global bit. The two centre cells lose feedback in dedicated-output mode and cannot serve as a dedicated input. A synchronous reset clears the flip-flop, as power-up reset does. A preload strobe loads the flip-flop from the pad, so test sequences can start from any state.

Top module: `plm_out_cell`

## Requirements
- R1: With mode bits {nreg,grp,io} = 010 (registered), the flip-flop loads on the rising clock edge. The pad output is the inverse of the flip-flop, the pad driver follows `share_oe`, and in a non-edge cell the feedback is the flip-flop value.
- R2: With {nreg,grp,io} = 011 or 111 (combinatorial I/O), the pad output is the OR of terms 0..NUM_TERMS-2 XOR `cfg_inv`. The pad enable equals the top term, and in a non-edge cell the feedback is `pad_in`.
- R3: With {nreg,grp,io} = 100 (dedicated output), the pad output is the OR of all terms XOR `cfg_inv`. The driver is always enabled, and in a cell that is neither edge nor centre the feedback is `nbr_pad_in`.
- R4: With {nreg,grp,io} = 101 (dedicated input), in a cell that is neither edge nor centre, the driver is off, the pad output is 0 and the feedback is `nbr_pad_in`.
- R5: In the combinatorial modes, `cfg_inv`=0 puts the OR result on the pad unchanged and `cfg_inv`=1 inverts it.
- R6: In the edge cells (index 0 and NUM_CELLS-1), the feedback selector uses `cfg_nreg` in place of `cfg_grp`. With that selector at 1 and `cfg_io`=1 the feedback is `pad_in`; with the selector at 1 and `cfg_io`=0 it is the flip-flop; with the selector at 0 it is `nbr_pad_in`. Pad output and enable follow R1 to R4 and R8.
- R7: In the centre cells (index NUM_CELLS/2-1 and NUM_CELLS/2), dedicated-output mode gives feedback 0. Code 101 behaves as reserved: driver off, pad output 0, feedback 0.
- R8: Codes 000, 001 and 110 are reserved: driver off, pad output 0, feedback 0.
- R9: When `rst` is high at a rising edge, the flip-flop clears to 0 whatever the D input or `preload_en` is. A registered pad then reads 1 for either polarity.
- R10: When `preload_en` is high and `rst` is low at a rising edge, the flip-flop loads `pad_in`, in any mode.
- R11: When neither `rst` nor `preload_en` is high at a rising edge, the flip-flop loads the OR of all terms XOR `cfg_inv`, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cfg_nreg | input | 1 | Global bit: device has no registers |
| cfg_grp | input | 1 | Global bit: selects the registered or combinatorial group |
| cfg_io | input | 1 | Cell role bit |
| cfg_inv | input | 1 | Cell polarity bit, 1 inverts |
| terms_in | input | NUM_TERMS | Product terms from the array |
| share_oe | input | 1 | Shared output enable, 1 drives |
| pad_in | input | 1 | Value read at the cell's pad |
| nbr_pad_in | input | 1 | Value read at the neighbouring pad |
| preload_en | input | 1 | Test preload strobe |
| pad_out | output | 1 | Value the pad driver drives |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
Reset and preload can both be requested on the same clock edge, and preload also competes with the normal D capture on every edge. Random stimulus raises `rst` and `preload_en` independently, so both coincide from time to time. A directed step raises both together with `pad_in`=1. The outcome is judged in the following cycle through the registered pad, or through the edge cell's feedback, against a bench model in which reset wins and preload beats D.

// File: rtl/plm_cell_pkg.sv
package plm_cell_pkg;
  typedef enum logic [2:0] {
    CM_REG  = 3'd0,
    CM_CIO  = 3'd1,
    CM_OUT  = 3'd2,
    CM_IN   = 3'd3,
    CM_RSVD = 3'd4
  } cell_mode_e;
endpackage

// File: rtl/plm_mode_dec.sv
module plm_mode_dec
  import plm_cell_pkg::*;
#(
  parameter bit CENTRE = 1'b0
) (
  input  logic       g_nreg,
  input  logic       g_grp,
  input  logic       l_io,
  output cell_mode_e mode
);
  always_comb begin
    unique case ({g_nreg, g_grp, l_io})
      3'b010:         mode = CM_REG;
      3'b011, 3'b111: mode = CM_CIO;
      3'b100:         mode = CM_OUT;
      3'b101:         mode = CENTRE ? CM_RSVD : CM_IN;
      default:        mode = CM_RSVD;
    endcase
  end
endmodule

// File: rtl/plm_sum.sv
module plm_sum
  import plm_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] terms,
  input  cell_mode_e           mode,
  input  logic                 inv,
  output logic                 comb_val,
  output logic                 d_val,
  output logic                 ctl_term
);
  localparam int CTL = NUM_TERMS - 1;

  logic or_all, or_low;
  always_comb begin
    or_all   = |terms;
    or_low   = |terms[CTL-1:0];
    d_val    = or_all ^ inv;
    comb_val = ((mode == CM_CIO) ? or_low : or_all) ^ inv;
    ctl_term = terms[CTL];
  end
endmodule

// File: rtl/plm_ff.sv
module plm_ff (
  input  logic clk,
  input  logic rst,
  input  logic load_pre,
  input  logic pre_val,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (load_pre) q <= pre_val;
    else               q <= d;
  end

  a_r10_preload_load: assert property (@(posedge clk) disable iff (rst)
    load_pre |=> (q == $past(pre_val)));
  a_r11_capture_d: assert property (@(posedge clk) disable iff (rst)
    !load_pre |=> (q == $past(d)));
endmodule

// File: rtl/plm_fb_mux.sv
module plm_fb_mux
  import plm_cell_pkg::*;
#(
  parameter bit CENTRE = 1'b0
) (
  input  cell_mode_e mode,
  input  logic       sel,
  input  logic       l_io,
  input  logic       pad_in,
  input  logic       nbr_in,
  input  logic       q,
  output logic       fb
);
  always_comb begin
    if (mode == CM_RSVD || (CENTRE && mode == CM_OUT)) fb = 1'b0;
    else begin
      unique case ({sel, l_io})
        2'b11:   fb = pad_in;
        2'b10:   fb = q;
        default: fb = nbr_in;
      endcase
    end
  end
endmodule

// File: rtl/plm_out_cell.sv
module plm_out_cell
  import plm_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  parameter int NUM_CELLS = 8,
  parameter int CELL_IDX  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_nreg,
  input  logic                 cfg_grp,
  input  logic                 cfg_io,
  input  logic                 cfg_inv,
  input  logic [NUM_TERMS-1:0] terms_in,
  input  logic                 share_oe,
  input  logic                 pad_in,
  input  logic                 nbr_pad_in,
  input  logic                 preload_en,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 fb_out
);
  localparam bit IS_EDGE   = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
  localparam bit IS_CENTRE = (CELL_IDX == NUM_CELLS/2 - 1) || (CELL_IDX == NUM_CELLS/2);
  localparam int CTL       = NUM_TERMS - 1;

  cell_mode_e mode;
  logic comb_val, d_val, ctl_term, q, fb_sel;

  plm_mode_dec #(.CENTRE(IS_CENTRE)) u_dec (
    .g_nreg(cfg_nreg), .g_grp(cfg_grp), .l_io(cfg_io), .mode(mode));

  plm_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .terms(terms_in), .mode(mode), .inv(cfg_inv),
    .comb_val(comb_val), .d_val(d_val), .ctl_term(ctl_term));

  plm_ff u_ff (
    .clk(clk), .rst(rst), .load_pre(preload_en), .pre_val(pad_in),
    .d(d_val), .q(q));

  generate
    if (IS_EDGE) begin : g_edge_sel
      assign fb_sel = cfg_nreg;
    end else begin : g_mid_sel
      assign fb_sel = cfg_grp;
    end
  endgenerate

  plm_fb_mux #(.CENTRE(IS_CENTRE)) u_fb (
    .mode(mode), .sel(fb_sel), .l_io(cfg_io), .pad_in(pad_in),
    .nbr_in(nbr_pad_in), .q(q), .fb(fb_out));

  always_comb begin
    unique case (mode)
      CM_REG:  begin pad_out = ~q;       pad_oe = share_oe; end
      CM_CIO:  begin pad_out = comb_val; pad_oe = ctl_term; end
      CM_OUT:  begin pad_out = comb_val; pad_oe = 1'b1;     end
      default: begin pad_out = 1'b0;     pad_oe = 1'b0;     end
    endcase
  end

  a_r1_reg_pad_tracks_d: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_REG && !preload_en) |=> (mode != CM_REG || pad_out == !$past(d_val)));
  a_r2_cio_enable_term: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_CIO) |-> (pad_oe == terms_in[CTL]));
  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_RSVD) |-> (!pad_oe && !pad_out && !fb_out));

  generate
    if (IS_CENTRE) begin : g_centre_chk
      a_r7_centre_no_fb: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_OUT) |-> !fb_out);
    end
    if (!IS_EDGE && !IS_CENTRE) begin : g_plain_chk
      a_r4_input_from_nbr: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_IN) |-> (!pad_oe && fb_out == nbr_pad_in));
    end
  endgenerate
endmodule

// File: tb/plm_out_cell_test.sv
module plm_out_cell_test;
  localparam int NT = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, nreg = 0, grp = 1, io = 0, inv = 0;
  logic [NT-1:0] terms = '0;
  logic soe = 0, pin = 0, nbr = 0, pre = 0;
  logic out_m, oe_m, fb_m, out_e, oe_e, fb_e, out_c, oe_c, fb_c;
  logic model_q = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  plm_out_cell #(.NUM_TERMS(NT), .NUM_CELLS(8), .CELL_IDX(2)) uut (
    .clk(clk), .rst(rst), .cfg_nreg(nreg), .cfg_grp(grp), .cfg_io(io), .cfg_inv(inv),
    .terms_in(terms), .share_oe(soe), .pad_in(pin), .nbr_pad_in(nbr), .preload_en(pre),
    .pad_out(out_m), .pad_oe(oe_m), .fb_out(fb_m));
  plm_out_cell #(.NUM_TERMS(NT), .NUM_CELLS(8), .CELL_IDX(0)) uut_edge (
    .clk(clk), .rst(rst), .cfg_nreg(nreg), .cfg_grp(grp), .cfg_io(io), .cfg_inv(inv),
    .terms_in(terms), .share_oe(soe), .pad_in(pin), .nbr_pad_in(nbr), .preload_en(pre),
    .pad_out(out_e), .pad_oe(oe_e), .fb_out(fb_e));
  plm_out_cell #(.NUM_TERMS(NT), .NUM_CELLS(8), .CELL_IDX(3)) uut_mid (
    .clk(clk), .rst(rst), .cfg_nreg(nreg), .cfg_grp(grp), .cfg_io(io), .cfg_inv(inv),
    .terms_in(terms), .share_oe(soe), .pad_in(pin), .nbr_pad_in(nbr), .preload_en(pre),
    .pad_out(out_c), .pad_oe(oe_c), .fb_out(fb_c));

  function automatic logic [2:0] expect_out(int idx);
    bit edge_c = (idx == 0 || idx == 7);
    bit cen = (idx == 3 || idx == 4);
    logic o, e, f, s;
    logic [2:0] code = {nreg, grp, io};
    bit rsv = (code == 3'b000 || code == 3'b001 || code == 3'b110 || (cen && code == 3'b101));
    o = 1'b0; e = 1'b0;
    if (code == 3'b010) begin o = ~model_q; e = soe; end
    else if (code == 3'b011 || code == 3'b111) begin o = (|terms[NT-2:0]) ^ inv; e = terms[NT-1]; end
    else if (code == 3'b100) begin o = (|terms) ^ inv; e = 1'b1; end
    s = edge_c ? nreg : grp;
    if (rsv || (cen && code == 3'b100)) f = 1'b0;
    else if (s && io) f = pin;
    else if (s) f = model_q;
    else f = nbr;
    return {o, e, f};
  endfunction

  function automatic string auto_tag(int idx);
    logic [2:0] code = {nreg, grp, io};
    if (idx == 0) return "R6";
    if (idx == 3 && (code == 3'b100 || code == 3'b101)) return "R7";
    case (code)
      3'b010: return "R1";
      3'b011, 3'b111: return "R2";
      3'b100: return "R3";
      3'b101: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check_one(string nm, int idx, logic [2:0] got, string tag);
    logic [2:0] exp = expect_out(idx);
    string t = (tag == "") ? auto_tag(idx) : tag;
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cell %s cfg=%b%b%b inv=%b got={out,oe,fb}=%b expected=%b",
               t, nm, nreg, grp, io, inv, got, exp);
    end
  endtask

  task automatic step(bit chk, string tag);
    #2;
    if (chk) begin
      check_one("mid2", 2, {out_m, oe_m, fb_m}, tag);
      check_one("edge0", 0, {out_e, oe_e, fb_e}, tag);
      check_one("centre3", 3, {out_c, oe_c, fb_c}, tag);
    end
    @(posedge clk);
    #1;
    model_q = rst ? 1'b0 : (pre ? pin : ((|terms) ^ inv));
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [2:0] c, logic p);
    {nreg, grp, io} = c; inv = p;
  endtask

  initial begin
    @(negedge clk);
    set_cfg(3'b010, 1'b0); terms = 8'hFF; soe = 1;
    step(0, ""); step(0, "");
    rst = 0;
    step(1, "R9");                      // reset state, active-high polarity
    rst = 1; inv = 1; step(0, "");
    rst = 0; step(1, "R9");             // reset state, inverted polarity
    // R5 polarity on a dedicated output
    set_cfg(3'b100, 1'b0); terms = 8'h01; step(1, "R5");
    inv = 1; step(1, "R5");
    terms = 8'h00; inv = 0; step(1, "R5");
    // R10 preload in registered mode, then observed
    set_cfg(3'b010, 1'b0); terms = 8'h00; pin = 1; pre = 1; step(1, "R1");
    pre = 0; pin = 0; step(1, "R10");
    // reset and preload together: reset wins (R9)
    rst = 1; pre = 1; pin = 1; step(0, "");
    rst = 0; pre = 0; pin = 0; step(1, "R9");
    // R11 capture in dedicated-output mode, seen on edge feedback
    set_cfg(3'b100, 1'b1); terms = 8'h00; step(1, "R3");
    step(1, "R11");
    // R2 enable term toggling
    set_cfg(3'b111, 1'b0); terms = 8'h80; pin = 1; step(1, "R2");
    terms = 8'h40; step(1, "R2");
    // R4 / R7 dedicated input, R8 reserved
    set_cfg(3'b101, 1'b0); nbr = 1; pin = 0; step(1, "");
    set_cfg(3'b110, 1'b1); terms = 8'hFF; step(1, "R8");
    begin
      int unsigned seed = 32'd2024;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        {nreg, grp, io, inv} = 4'($urandom);
        terms = NT'($urandom);
        if ($urandom_range(0, 3) == 0) terms = '0;
        soe = 1'($urandom); pin = 1'($urandom); nbr = 1'($urandom);
        pre = ($urandom_range(0, 7) == 0);
        rst = ($urandom_range(0, 31) == 0);
        step(1, "");
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule